// File: doc/BRIEF.md
# Duty-Cycled Receiver Polling Sequencer

This block is the wake-up controller of a low-power radio receiver. While polling, it keeps the signal path off for a programmable sleep time. It then powers the path up for a start-up time that depends on the baud range. Next it opens a bit-check window, in which an external checker judges whether a real transmitter is present. A pass makes the receiver stay on permanently. A fail sends it straight back to sleep.

All timing is counted in basic ticks. A basic tick is the input clock divided by `TICK_DIV`, which is 14 by default.

Sleep length in ticks is the sleep word times an extension factor times 2^`SLEEP_UNIT_LG`. The extension factor is 1, or 8 when the extension bit is set. The unit is 1024 ticks by default. The all-ones sleep word parks the receiver in sleep until a different word is applied.

An external on/polling pin can force the receiver on at any time. While the receiver is on, an OFF command or the pin returning high drops it back into the polling cycle.

Top module: `rx_poll_seq`

## Requirements
- R1: While reset is asserted, `active_o`, `path_en_o` and `chk_en_o` are low. After reset is released the block starts a complete sleep phase.
- R2: With `sleep_ext_i` low, a sleep phase lasts max(1, W × 2^SLEEP_UNIT_LG) ticks, where W is `sleep_word_i`. Every timed phase starts counting at its own entry and lasts exactly its tick count × TICK_DIV clock cycles.
- R3: With `sleep_ext_i` high, the sleep length is max(1, W × 8 × 2^SLEEP_UNIT_LG) ticks.
- R4: When W is all ones (31), the block stays in sleep indefinitely. After W changes to another value, the sleep timer restarts from zero and the block wakes after the new sleep length. Because the tick divider keeps running, the wake point has up to one tick of jitter.
- R5: Start-up lasts max(1, STARTUP_TICKS[`baud_sel_i`]) ticks, and is followed by the bit-check phase. Entry k of `STARTUP_TICKS` sits at bits [8k+7:8k].
- R6: In bit-check, `chk_en_o` is high. A `chk_done_i` pulse with `chk_pass_i`=1 enters receiving on the next cycle. A pulse with `chk_pass_i`=0 enters sleep on the next cycle. `chk_done_i` has no effect in any other phase, and `chk_en_o` is low outside bit-check.
- R7: `active_o` and `path_en_o` are low in sleep and high in start-up, bit-check and receiving.
- R8: In receiving with `poll_on_i` high, `off_cmd_i` returns the block to sleep on the next cycle. While `poll_on_i` is low, `off_cmd_i` is ignored.
- R9: `poll_on_i` low puts the block in receiving on the next cycle from any phase, including the permanent sleep code. A low-to-high transition of `poll_on_i` while receiving returns the block to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock from which basic ticks are divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_word_i | input | SLEEP_W | Sleep length word; all ones means sleep forever |
| sleep_ext_i | input | 1 | Sleep extension: 0 gives factor 1, 1 gives factor 8 |
| baud_sel_i | input | 2 | Baud range; selects the start-up tick count |
| chk_done_i | input | 1 | Bit checker result strobe |
| chk_pass_i | input | 1 | Bit checker verdict, valid with chk_done_i |
| poll_on_i | input | 1 | High: polling mode; low: force receiving |
| off_cmd_i | input | 1 | Command pulse that ends receiving |
| active_o | output | 1 | Receiver active status |
| path_en_o | output | 1 | Signal path power enable |
| chk_en_o | output | 1 | Enables the external bit checker |

## Verification
The embedded properties watch every cycle for the single-step transitions:
- the checker verdict routing,
- the OFF exit,
- the pin override,
- the hold on the permanent sleep code,
- bit-check being entered only from start-up,
- tick spacing and timer bounds.

Only the bench scenarios can show the interval properties:
- exact sleep and start-up durations for every word, extension setting and baud range;
- the wake jitter after leaving permanent sleep;
- the fact that a checker strobe during sleep leaves the sleep length unchanged.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;
  localparam int BAUD_W = 2;
  localparam int NBAUD  = 1 << BAUD_W;
  localparam int XSHIFT = 3;  // extension factor 8

  typedef enum logic [1:0] {
    PH_SLEEP   = 2'd0,
    PH_STARTUP = 2'd1,
    PH_CHECK   = 2'd2,
    PH_RECV    = 2'd3
  } poll_phase_e;
endpackage

// File: rtl/rx_poll_tick.sv
module rx_poll_tick #(
  parameter int TICK_DIV = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
  parameter int LW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          hold_i,
  input  logic          tick_i,
  input  logic [LW-1:0] len_i,
  output logic          done_o
);
  logic [LW-1:0] cnt_q;

  // zero length finishes on the first tick
  assign done_o = tick_i && !hold_i && ((cnt_q + LW'(1)) >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || hold_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + LW'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '1); // R2
endmodule

// File: rtl/rx_poll_sleep_len.sv
module rx_poll_sleep_len
  import rx_poll_pkg::*;
#(
  parameter int SLEEP_W       = 5,
  parameter int SLEEP_UNIT_LG = 10,
  parameter int LW            = SLEEP_W + XSHIFT + SLEEP_UNIT_LG + 1
) (
  input  logic [SLEEP_W-1:0] word_i,
  input  logic               ext_i,
  output logic [LW-1:0]      len_o,
  output logic               perm_o
);
  logic [LW-1:0] base;

  always_comb begin
    base   = LW'(word_i) << SLEEP_UNIT_LG;
    len_o  = ext_i ? (base << XSHIFT) : base;
    perm_o = (word_i == '1);
  end
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
  import rx_poll_pkg::*;
#(
  parameter int                     TICK_DIV      = 14,
  parameter int                     SLEEP_W       = 5,
  parameter int                     SLEEP_UNIT_LG = 10,
  parameter logic [NBAUD-1:0][7:0]  STARTUP_TICKS = {8'd12, 8'd24, 8'd48, 8'd96}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLEEP_W-1:0] sleep_word_i,
  input  logic               sleep_ext_i,
  input  logic [BAUD_W-1:0]  baud_sel_i,
  input  logic               chk_done_i,
  input  logic               chk_pass_i,
  input  logic               poll_on_i,
  input  logic               off_cmd_i,
  output logic               active_o,
  output logic               path_en_o,
  output logic               chk_en_o
);
  localparam int LW = SLEEP_W + XSHIFT + SLEEP_UNIT_LG + 1;

  poll_phase_e   state_q, state_d;
  logic          pin_q;
  logic          tick, done, perm, hold, phase_chg;
  logic [LW-1:0] sleep_len, startup_len, len;

  assign phase_chg = (state_d != state_q);

  rx_poll_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (phase_chg),
    .tick_o  (tick)
  );

  rx_poll_sleep_len #(
    .SLEEP_W       (SLEEP_W),
    .SLEEP_UNIT_LG (SLEEP_UNIT_LG),
    .LW            (LW)
  ) u_len (
    .word_i (sleep_word_i),
    .ext_i  (sleep_ext_i),
    .len_o  (sleep_len),
    .perm_o (perm)
  );

  assign startup_len = LW'(STARTUP_TICKS[baud_sel_i]);
  assign len         = (state_q == PH_SLEEP) ? sleep_len : startup_len;
  assign hold        = (state_q == PH_CHECK) || (state_q == PH_RECV) ||
                       ((state_q == PH_SLEEP) && perm);

  rx_poll_timer #(.LW(LW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (phase_chg),
    .hold_i  (hold),
    .tick_i  (tick),
    .len_i   (len),
    .done_o  (done)
  );

  always_comb begin
    state_d = state_q;
    if (!poll_on_i) begin
      state_d = PH_RECV;
    end else begin
      unique case (state_q)
        PH_SLEEP:   if (done) state_d = PH_STARTUP;
        PH_STARTUP: if (done) state_d = PH_CHECK;
        PH_CHECK:   if (chk_done_i) state_d = chk_pass_i ? PH_RECV : PH_SLEEP;
        PH_RECV:    if (!pin_q || off_cmd_i) state_d = PH_SLEEP;  // !pin_q: pin just rose
        default:    state_d = PH_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_SLEEP;
      pin_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      pin_q   <= poll_on_i;
    end
  end

  assign active_o  = (state_q != PH_SLEEP);
  assign path_en_o = (state_q != PH_SLEEP);
  assign chk_en_o  = (state_q == PH_CHECK);

  AST_PIN_FORCES_RECV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_on_i |=> state_q == PH_RECV); // R9
  AST_PASS_TO_RECV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_CHECK && poll_on_i && chk_done_i && chk_pass_i) |=> state_q == PH_RECV); // R6
  AST_FAIL_TO_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_CHECK && poll_on_i && chk_done_i && !chk_pass_i) |=> state_q == PH_SLEEP); // R6
  AST_OFF_TO_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_RECV && poll_on_i && off_cmd_i) |=> state_q == PH_SLEEP); // R8
  AST_PERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SLEEP && poll_on_i && sleep_word_i == '1) |=> state_q == PH_SLEEP); // R4
  AST_CHECK_AFTER_STARTUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chk_en_o) |-> $past(state_q) == PH_STARTUP); // R5
endmodule

// File: tb/sim_rx_poll_seq.sv
module sim_rx_poll_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int ULG = 2;

  logic clk = 0, rst_n = 0;
  logic [4:0] word = 0;
  logic ext = 0, done = 0, pass = 0, pin = 1, off = 0;
  logic [1:0] baud = 0;
  logic active, path_en, chk_en;
  int checks = 0, errors = 0, mism = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_poll_seq #(
    .TICK_DIV(DIV), .SLEEP_W(5), .SLEEP_UNIT_LG(ULG),
    .STARTUP_TICKS({8'd0, 8'd2, 8'd3, 8'd5})
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_word_i(word), .sleep_ext_i(ext),
    .baud_sel_i(baud), .chk_done_i(done), .chk_pass_i(pass), .poll_on_i(pin),
    .off_cmd_i(off), .active_o(active), .path_en_o(path_en), .chk_en_o(chk_en)
  );

  always @(negedge clk) if (rst_n && ((path_en !== active) || (chk_en && !active))) mism++;

  function automatic int exp_sleep(int w, bit x);
    int l = w * (x ? 8 : 1) * (1 << ULG);
    return ((l < 1) ? 1 : l) * DIV;
  endfunction

  function automatic int exp_start(int b);
    int t[4] = '{5, 3, 2, 0};
    return ((t[b] < 1) ? 1 : t[b]) * DIV;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_low(input int inject, output int n);
    n = 0;
    while (active == 0 && n < 20000) begin
      done = (n == inject);
      pass = (n == inject);
      n++;
      @(negedge clk);
    end
    done = 0; pass = 0;
  endtask

  task automatic count_startup(output int n);
    n = 0;
    while (active == 1 && chk_en == 0 && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_done(input logic p);
    done = 1; pass = p;
    @(negedge clk);
    done = 0; pass = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 active in reset", active, 0);
    check("R1 path_en in reset", path_en, 0);
    check("R1 chk_en in reset", chk_en, 0);
    rst_n = 1;
    count_low(-1, n);
    check("R1 first sleep", n, exp_sleep(0, 0));
    count_startup(n);
    check("R5 first startup", n, exp_start(0));

    // sweep of sleep words, extension and baud ranges
    for (int x = 0; x < 2; x++) begin
      for (int w = 0; w < 31; w++) begin
        word = 5'(w); ext = x[0]; baud = 2'(w % 4);
        pulse_done(0);
        count_low(-1, n);
        check(x ? "R3 sleep ext" : "R2 sleep", n, exp_sleep(w, x[0]));
        count_startup(n);
        check("R5 startup", n, exp_start(w % 4));
      end
    end

    // strobe during sleep is ignored
    word = 5; ext = 0; baud = 1;
    pulse_done(0);
    count_low(10, n);
    check("R6 strobe in sleep ignored", n, exp_sleep(5, 0));
    count_startup(n);
    check("R6 then startup", n, exp_start(1));
    check("R6 chk_en in check", chk_en, 1);

    // pass enters receiving
    pulse_done(1);
    check("R6 pass active", active, 1);
    check("R6 chk_en low in recv", chk_en, 0);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!active) n++;
    end
    check("R6 recv persists", n, 0);

    // OFF ignored while pin low, pin rise ends receiving
    pin = 0; @(negedge clk);
    off = 1; @(negedge clk); off = 0;
    @(negedge clk);
    check("R8 off ignored with pin low", active, 1);
    pin = 1; @(negedge clk);
    check("R9 pin rise to sleep", active, 0);
    count_low(-1, n);
    check("R2 sleep after pin", n, exp_sleep(5, 0));
    count_startup(n);
    pulse_done(1);
    check("R6 pass again", active, 1);
    off = 1; @(negedge clk); off = 0;
    check("R8 off to sleep", active, 0);

    // pin low from sleep
    @(negedge clk);
    pin = 0; @(negedge clk);
    check("R9 pin wakes", active, 1);
    check("R9 no check in recv", chk_en, 0);
    pin = 1; @(negedge clk);
    check("R9 pin release", active, 0);

    // permanent sleep
    word = 31;
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (active) n++;
    end
    check("R4 perm sleep", n, 0);
    word = 1; ext = 0;
    count_low(-1, n);
    checks++;
    if (n < exp_sleep(1, 0) - DIV + 1 || n > exp_sleep(1, 0)) begin
      errors++;
      $display("FAIL R4 wake after perm: actual %0d expected %0d..%0d", n,
               exp_sleep(1, 0) - DIV + 1, exp_sleep(1, 0));
    end
    count_startup(n);
    word = 31;
    pulse_done(0);
    check("R6 fail to perm sleep", active, 0);
    repeat (50) @(negedge clk);
    pin = 0; @(negedge clk);
    check("R9 pin wakes perm", active, 1);
    pin = 1; @(negedge clk);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (active) n++;
    end
    check("R4 perm after pin", n, 0);

    check("R7 path_en tracks active", mism, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule